// File: doc/BRIEF.md
# SD Card SPI-Mode Start-Up Sequencer

This block takes a memory card from power-up into SPI mode and walks it through the setup commands. Only after that may the host run normal transfers. It owns the chip select, the serial clock and the MOSI line, and it samples MISO. It builds every 48-bit command frame itself, including the CRC7, and reads the responses byte by byte. It reports the result on a small status interface: `done` for success, or `err` with a two-bit code. It also raises a flag that tells the host it may now move the card to the fast clock.

A pulse on `start` begins the sequence. First come `PRE_BYTES` wake bytes (80 clocks by default) with the card deselected. Then the block sends the go-idle command (index 0). Next it sends the operating-condition command (index 1) with the high-capacity flag. It repeats that command while the card still reports idle. Last it sends the interface-condition command (index 8). The 12-bit echo in that command's reply must match the check pattern that was sent. All of this traffic runs with the serial clock half period set by `SLOW_HALF`.

The controller is built around one state machine:
- States: `ST_IDLE`, `ST_WAKE`, `ST_CMD`, `ST_POLL`, `ST_R7`, `ST_SPACE`, `ST_DONE`, `ST_FAIL`.
- Start transitions: IDLE/DONE/FAIL→WAKE on `start`; WAKE→CMD after the last wake byte; CMD→POLL after frame byte 5.
- Transitions out of POLL: POLL→SPACE on a valid R1; POLL→R7 on the index-8 R1; POLL→FAIL on timeout or when the retry limit is used up.
- Closing transitions: R7→SPACE or FAIL after the fourth trailing byte; SPACE→CMD for the next command; SPACE→DONE after the last command.

Top module: `sdspi_boot_seq`

## Requirements
- R1: After reset the outputs are `cs_n`=1, `sclk`=0, `mosi`=1, `busy`=0, `done`=0, `err`=0 and `fast_ok`=0.
- R2: After `start`, exactly `PRE_BYTES`*8 rising edges of `sclk` (80 by default, at least 74) occur with `cs_n` high. During them `mosi` is held at 1, and this comes before any command bit.
- R3: During the sequence the clock runs in mode 0. `sclk` idles low and each high phase lasts exactly `SLOW_HALF` system clocks. MOSI changes only after a falling edge, and MISO is sampled at the rising edge.
- R4: Each command frame is sent MSB first, 48 bits in this order: `01`, the 6-bit index, the 32-bit argument, a CRC7 over the first 40 bits (polynomial x^7+x^3+1, zero start) and a stop bit of 1. For the go-idle command the last byte is 0x95.
- R5: The command order is fixed: index 0 with argument 0, then index 1 with argument 0x4000_0000 (once or more), then index 8 with argument 0x0000_01A5. `cs_n` falls exactly once per run, at the first bit of the index-0 frame, and stays low until the run ends.
- R6: After each frame, up to `POLL_MAX` (8) bytes are read. The first byte with bit 7 = 0 is the R1 response. If no such byte arrives, the block stops with `err`=1 and code 1.
- R7: The index-1 command is sent again while R1 bit 0 (idle) is 1, up to `CMD1_TRIES` sends. If the last allowed send is still answered with idle, the block stops with code 2.
- R8: After the index-8 R1, four more bytes are read. The low nibble of the third byte followed by the fourth byte must equal 0x1A5. On a mismatch the block stops with code 3.
- R9: On success `done`=1, `fast_ok`=1, `err`=0 and `busy`=0. On any error `err`=1, `done`=0 and `fast_ok`=0. In both end states `cs_n` is high and no further clocks are sent.
- R10: A `start` pulse in the idle, done or failed state begins a new run from the wake stage. In the next cycle `busy`=1 and both `done` and `err` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to run the start-up sequence |
| miso | input | 1 | Serial data from the card |
| sclk | output | 1 | Serial clock to the card, mode 0 |
| cs_n | output | 1 | Card select, active low |
| mosi | output | 1 | Serial data to the card |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished successfully |
| err | output | 1 | Sequence stopped on an error |
| err_code | output | 2 | 0 none, 1 response timeout, 2 retries used up, 3 echo mismatch |
| fast_ok | output | 1 | Host may switch the card to the fast clock |

## Verification
Two decisions can land on the same response byte. One is accepting an R1 on the last permitted poll; the other is declaring a timeout on that same poll. Likewise, the last allowed operating-condition retry can coincide with the card leaving idle. The bench provokes these cases with a card model that holds back its reply by exactly seven and exactly eight filler bytes, and that stays idle for exactly `CMD1_TRIES`-1 and `CMD1_TRIES` sends. A bench function predicts the resulting frame list and end code, and the observed frames and code are judged against that prediction.

// File: rtl/sdboot_pkg.sv
package sdboot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_CMD,
        ST_POLL,
        ST_R7,
        ST_SPACE,
        ST_DONE,
        ST_FAIL
    } seq_state_t;

    typedef enum logic [1:0] {
        CM_GO_IDLE,
        CM_INIT,
        CM_IF_COND,
        CM_FINISH
    } cmd_t;

    typedef enum logic [1:0] {
        EC_NONE    = 2'd0,
        EC_TIMEOUT = 2'd1,
        EC_RETRY   = 2'd2,
        EC_ECHO    = 2'd3
    } err_t;

    localparam logic [5:0] IDX_GO_IDLE = 6'd0;
    localparam logic [5:0] IDX_INIT    = 6'd1;
    localparam logic [5:0] IDX_IF_COND = 6'd8;
    localparam int         FRAME_BYTES = 6;

    // Serial CRC7, generator x^7 + x^3 + 1, register starts at zero.
    function automatic logic [6:0] crc7_of(input logic [39:0] bits);
        logic [6:0] c;
        logic       fb;
        c = '0;
        for (int i = 39; i >= 0; i--) begin
            fb = bits[i] ^ c[6];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

endpackage

// File: rtl/sdboot_bytex.sv
// One-byte mode-0 exchanger: shifts tx out MSB first, samples miso on rise.
module sdboot_bytex #(
    parameter int HALF = 125
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx
);
    localparam int             DW      = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [DW-1:0]  DIV_END = DW'(HALF - 1);

    logic          active;
    logic          sclk_q;
    logic [DW-1:0] div;
    logic [2:0]    bitn;
    logic [7:0]    sh_tx;
    logic [7:0]    sh_rx;
    logic          done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            sclk_q <= 1'b0;
            div    <= '0;
            bitn   <= '0;
            sh_tx  <= 8'hFF;
            sh_rx  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active) begin
                if (go) begin
                    active <= 1'b1;
                    sh_tx  <= tx;
                    div    <= '0;
                    bitn   <= '0;
                    sclk_q <= 1'b0;
                end
            end else if (div == DIV_END) begin
                div <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    sh_rx  <= {sh_rx[6:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    if (bitn == 3'd7) begin
                        active <= 1'b0;
                        done_q <= 1'b1;
                        sh_tx  <= 8'hFF;
                    end else begin
                        bitn  <= bitn + 3'd1;
                        sh_tx <= {sh_tx[6:0], 1'b1};
                    end
                end
            end else begin
                div <= div + DW'(1);
            end
        end
    end

    always_comb begin
        sclk = sclk_q;
        mosi = sh_tx[7];
        busy = active;
        done = done_q;
        rx   = sh_rx;
    end

    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_sclk_in_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> busy);

endmodule

// File: rtl/sdboot_frame.sv
// Builds the six bytes of a command frame and selects one of them.
module sdboot_frame
    import sdboot_pkg::*;
#(
    parameter logic [31:0] HCS_ARG = 32'h4000_0000,
    parameter logic [31:0] IF_ARG  = 32'h0000_01A5
) (
    input  cmd_t       cmd,
    input  logic [2:0] sel,
    output logic [7:0] frame_byte
);
    logic [5:0]  idx;
    logic [31:0] arg;
    logic [39:0] head;
    logic [47:0] frame;
    logic [7:0]  fbytes [8];

    always_comb begin
        case (cmd)
            CM_GO_IDLE: begin idx = IDX_GO_IDLE; arg = 32'h0;   end
            CM_INIT:    begin idx = IDX_INIT;    arg = HCS_ARG; end
            CM_IF_COND: begin idx = IDX_IF_COND; arg = IF_ARG;  end
            default:    begin idx = IDX_GO_IDLE; arg = 32'h0;   end
        endcase
        head  = {2'b01, idx, arg};
        frame = {head, crc7_of(head), 1'b1};
    end

    for (genvar g = 0; g < 8; g++) begin : g_bytes
        if (g < FRAME_BYTES) begin : g_live
            assign fbytes[g] = frame[47 - 8*g -: 8];
        end else begin : g_pad
            assign fbytes[g] = 8'hFF;
        end
    end

    assign frame_byte = fbytes[sel];

endmodule

// File: rtl/sdspi_boot_seq.sv
module sdspi_boot_seq
    import sdboot_pkg::*;
#(
    parameter int          SLOW_HALF  = 125,
    parameter int          PRE_BYTES  = 10,
    parameter int          POLL_MAX   = 8,
    parameter int          CMD1_TRIES = 1000,
    parameter logic [31:0] HCS_ARG    = 32'h4000_0000,
    parameter logic [31:0] IF_ARG     = 32'h0000_01A5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       miso,
    output logic       sclk,
    output logic       cs_n,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic       err,
    output logic [1:0] err_code,
    output logic       fast_ok
);
    localparam int CNT_TOP = (PRE_BYTES > POLL_MAX) ?
                             ((PRE_BYTES > 4) ? PRE_BYTES : 4) :
                             ((POLL_MAX > 4) ? POLL_MAX : 4);
    localparam int CW = $clog2(CNT_TOP + 1);
    localparam int TW = $clog2(CMD1_TRIES + 1);
    localparam logic [11:0] ECHO = IF_ARG[11:0];

    seq_state_t     state;
    cmd_t           cmd;
    cmd_t           nxt_cmd;
    err_t           ec;
    logic [CW-1:0]  cnt;
    logic [TW-1:0]  tries;
    logic [2:0]     bidx;
    logic [3:0]     r7_nib;

    logic           bx_go;
    logic [7:0]     bx_tx;
    logic           bx_busy;
    logic           bx_done;
    logic [7:0]     bx_rx;
    logic [7:0]     fr_byte;
    logic           need_byte;

    sdboot_frame #(
        .HCS_ARG (HCS_ARG),
        .IF_ARG  (IF_ARG)
    ) u_frame (
        .cmd        (cmd),
        .sel        (bidx),
        .frame_byte (fr_byte)
    );

    sdboot_bytex #(
        .HALF (SLOW_HALF)
    ) u_bytex (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (bx_go),
        .tx    (bx_tx),
        .miso  (miso),
        .sclk  (sclk),
        .mosi  (mosi),
        .busy  (bx_busy),
        .done  (bx_done),
        .rx    (bx_rx)
    );

    // State register and sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cmd     <= CM_GO_IDLE;
            nxt_cmd <= CM_GO_IDLE;
            ec      <= EC_NONE;
            cnt     <= '0;
            tries   <= '0;
            bidx    <= '0;
            r7_nib  <= '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_DONE, ST_FAIL: begin
                    if (start) begin
                        state <= ST_WAKE;
                        ec    <= EC_NONE;
                        cnt   <= '0;
                        tries <= '0;
                    end
                end
                ST_WAKE: begin
                    if (bx_done) begin
                        if (cnt == CW'(PRE_BYTES - 1)) begin
                            state <= ST_CMD;
                            cmd   <= CM_GO_IDLE;
                            bidx  <= '0;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
                ST_CMD: begin
                    if (bx_done) begin
                        if (bidx == 3'(FRAME_BYTES - 1)) begin
                            state <= ST_POLL;
                            cnt   <= '0;
                        end else begin
                            bidx <= bidx + 3'd1;
                        end
                    end
                end
                ST_POLL: begin
                    if (bx_done) begin
                        if (!bx_rx[7]) begin
                            case (cmd)
                                CM_GO_IDLE: begin
                                    state   <= ST_SPACE;
                                    nxt_cmd <= CM_INIT;
                                    tries   <= TW'(1);
                                end
                                CM_INIT: begin
                                    if (bx_rx[0]) begin
                                        if (tries == TW'(CMD1_TRIES)) begin
                                            state <= ST_FAIL;
                                            ec    <= EC_RETRY;
                                        end else begin
                                            state   <= ST_SPACE;
                                            nxt_cmd <= CM_INIT;
                                            tries   <= tries + TW'(1);
                                        end
                                    end else begin
                                        state   <= ST_SPACE;
                                        nxt_cmd <= CM_IF_COND;
                                    end
                                end
                                CM_IF_COND: begin
                                    state <= ST_R7;
                                    cnt   <= '0;
                                end
                                default: begin
                                    state <= ST_FAIL;
                                    ec    <= EC_TIMEOUT;
                                end
                            endcase
                        end else if (cnt == CW'(POLL_MAX - 1)) begin
                            state <= ST_FAIL;
                            ec    <= EC_TIMEOUT;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
                ST_R7: begin
                    if (bx_done) begin
                        r7_nib <= bx_rx[3:0];
                        if (cnt == CW'(3)) begin
                            if ({r7_nib, bx_rx} == ECHO) begin
                                state   <= ST_SPACE;
                                nxt_cmd <= CM_FINISH;
                            end else begin
                                state <= ST_FAIL;
                                ec    <= EC_ECHO;
                            end
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
                ST_SPACE: begin
                    if (bx_done) begin
                        if (nxt_cmd == CM_FINISH) begin
                            state <= ST_DONE;
                        end else begin
                            state <= ST_CMD;
                            cmd   <= nxt_cmd;
                            bidx  <= '0;
                        end
                    end
                end
            endcase
        end
    end

    // Outputs and byte-engine requests
    always_comb begin
        need_byte = (state == ST_WAKE) || (state == ST_CMD) || (state == ST_POLL) ||
                    (state == ST_R7)   || (state == ST_SPACE);
        bx_go     = need_byte && !bx_busy && !bx_done;
        bx_tx     = (state == ST_CMD) ? fr_byte : 8'hFF;
        cs_n      = !((state == ST_CMD) || (state == ST_POLL) ||
                      (state == ST_R7)  || (state == ST_SPACE));
        busy      = need_byte;
        done      = (state == ST_DONE);
        err       = (state == ST_FAIL);
        err_code  = ec;
        fast_ok   = (state == ST_DONE);
    end

    p_quiet_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && mosi && cs_n));
    p_mosi_high_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> mosi);
    p_cs_first_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (cmd == CM_GO_IDLE && bidx == 3'd0));
    p_poll_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POLL) |-> (cnt < CW'(POLL_MAX)));
    p_tries_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tries <= TW'(CMD1_TRIES));
    p_end_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
    p_fast_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fast_ok |-> (done && err_code == 2'd0));

endmodule

// File: tb/tb_sdspi_boot_seq.sv
module tb_sdspi_boot_seq;

    localparam int HALF  = 4;
    localparam int TRIES = 6;
    localparam int PREB  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic miso = 1'b1;
    logic sclk, cs_n, mosi, busy, done, err, fast_ok;
    logic [1:0] err_code;

    always #5 clk = ~clk;

    sdspi_boot_seq #(
        .SLOW_HALF  (HALF),
        .PRE_BYTES  (PREB),
        .CMD1_TRIES (TRIES)
    ) dut (
        .clk (clk), .rst_n (rst_n), .start (start), .miso (miso),
        .sclk (sclk), .cs_n (cs_n), .mosi (mosi), .busy (busy),
        .done (done), .err (err), .err_code (err_code), .fast_ok (fast_ok)
    );

    int total = 0;
    int bad   = 0;

    // scenario configuration (written by the stimulus only)
    int          cfg_lat0, cfg_lat1, cfg_lat8, cfg_idle;
    logic [11:0] cfg_echo;

    // card model state and cumulative logs (written by the card only)
    int          nfr = 0, crc_bad = 0, pre_edges = 0, pre_mosi_bad = 0;
    int          fidx [0:255];
    logic [31:0] farg [0:255];
    logic [7:0]  flast[0:255];
    int          bitc = 0, fpos = 0, qlen = 0, qpos = 0, c1n = 0;
    logic [7:0]  rxb = 8'h00, txsh = 8'hFF, nb;
    logic [7:0]  fbuf [0:5];
    logic [7:0]  q [0:15];

    // monitors on the system clock
    int   cs_falls = 0, hi_bad = 0, hi_cnt = 0;
    logic prev_cs = 1'b1;

    function automatic logic [6:0] ref_crc(input logic [39:0] d);
        logic [46:0] r;
        r = {d, 7'b0};
        for (int i = 46; i >= 7; i--)
            if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
        return r[6:0];
    endfunction

    function automatic logic [31:0] exp_arg(input int idx);
        if (idx == 1) return 32'h4000_0000;
        if (idx == 8) return 32'h0000_01A5;
        return 32'h0;
    endfunction

    always @(negedge clk) begin
        if (prev_cs && !cs_n) cs_falls++;
        prev_cs = cs_n;
        if (sclk) hi_cnt++;
        else if (hi_cnt != 0) begin
            if (hi_cnt != HALF) hi_bad++;
            hi_cnt = 0;
        end
    end

    // card behaviour: sample MOSI on the rise, drive MISO after the fall
    always @(sclk) begin
        if (sclk === 1'b1) begin
            if (cs_n) begin
                pre_edges++;
                if (!mosi) pre_mosi_bad++;
                bitc = 0; qlen = 0; qpos = 0; c1n = 0; fpos = 0;
                txsh = 8'hFF; miso = 1'b1;
            end else begin
                rxb = {rxb[6:0], mosi};
                bitc++;
            end
        end else if (sclk === 1'b0 && cs_n === 1'b0) begin
            if (bitc == 8) begin
                bitc = 0;
                if (fpos == 0 && rxb[7:6] == 2'b01) begin
                    fbuf[0] = rxb; fpos = 1;
                end else if (fpos > 0) begin
                    fbuf[fpos] = rxb; fpos++;
                    if (fpos == 6) begin
                        int lat;
                        int idx;
                        fpos = 0;
                        idx = int'(fbuf[0][5:0]);
                        if (ref_crc({fbuf[0], fbuf[1], fbuf[2], fbuf[3], fbuf[4]}) != fbuf[5][7:1]
                            || !fbuf[5][0]) crc_bad++;
                        fidx[nfr]  = idx;
                        farg[nfr]  = {fbuf[1], fbuf[2], fbuf[3], fbuf[4]};
                        flast[nfr] = fbuf[5];
                        if (nfr < 255) nfr++;
                        lat  = (idx == 0) ? cfg_lat0 : (idx == 1) ? cfg_lat1 : cfg_lat8;
                        qlen = 0; qpos = 0;
                        for (int k = 0; k < lat; k++) begin q[qlen] = 8'hFF; qlen++; end
                        if (idx == 1) begin
                            c1n++;
                            q[qlen] = (c1n <= cfg_idle) ? 8'h01 : 8'h00; qlen++;
                        end else if (idx == 8) begin
                            q[qlen] = 8'h01; q[qlen+1] = 8'h00; q[qlen+2] = 8'h00;
                            q[qlen+3] = {4'h0, cfg_echo[11:8]}; q[qlen+4] = cfg_echo[7:0];
                            qlen += 5;
                        end else begin
                            q[qlen] = 8'h01; qlen++;
                        end
                    end
                end
                nb = (qpos < qlen) ? q[qpos] : 8'hFF;
                if (qpos < qlen) qpos++;
                miso = nb[7];
                txsh = {nb[6:0], 1'b1};
            end else begin
                miso = txsh[7];
                txsh = {txsh[6:0], 1'b1};
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic run_case(input int l0, input int l1, input int l8, input int idl,
                            input logic [11:0] ech);
        int b_fr, b_crc, b_pre, b_pmb, b_cs, b_hi, cyc, efr, ecode, nf;
        int eidx [0:15];
        string tag;
        cfg_lat0 = l0; cfg_lat1 = l1; cfg_lat8 = l8; cfg_idle = idl; cfg_echo = ech;
        b_fr = nfr; b_crc = crc_bad; b_pre = pre_edges; b_pmb = pre_mosi_bad;
        b_cs = cs_falls; b_hi = hi_bad;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        // R10: a new run clears the flags at once
        check(busy && !done && !err, "R10 restart", {busy, done, err}, 3'b100);
        cyc = 0;
        while (!(done || err) && cyc < 40000) begin @(negedge clk); cyc++; end
        check(cyc < 40000, "R9 run ended (watchdog)", cyc, 40000);

        // predicted frame list and end code
        efr = 0; ecode = 0;
        eidx[efr] = 0; efr++;
        if (l0 > 7) ecode = 1;
        else begin
            bit ready = 1'b0;
            for (int a = 1; a <= TRIES; a++) begin
                eidx[efr] = 1; efr++;
                if (l1 > 7) begin ecode = 1; break; end
                if (a > idl) begin ready = 1'b1; break; end
            end
            if (ecode == 0 && !ready) ecode = 2;
            if (ecode == 0) begin
                eidx[efr] = 8; efr++;
                if (l8 > 7) ecode = 1;
                else if (ech != 12'h1A5) ecode = 3;
            end
        end

        tag = (ecode == 0) ? "R9 outcome" : (ecode == 1) ? "R6 timeout" :
              (ecode == 2) ? "R7 retries" : "R8 echo";
        check(done == (ecode == 0) && err == (ecode != 0) && err_code == 2'(ecode),
              tag, {done, err, err_code}, {(ecode == 0), (ecode != 0), 2'(ecode)});
        check(cs_n && !busy && fast_ok == done, "R9 end state", {cs_n, busy, fast_ok},
              {1'b1, 1'b0, done});
        nf = nfr - b_fr;
        check(nf == efr, "R5 frame count", nf, efr);
        for (int i = 0; i < efr && i < nf; i++) begin
            check(fidx[b_fr+i] == eidx[i] && farg[b_fr+i] == exp_arg(eidx[i]),
                  "R5 frame order", {fidx[b_fr+i], farg[b_fr+i]},
                  {eidx[i], exp_arg(eidx[i])});
        end
        if (nf > 0) check(flast[b_fr] == 8'h95, "R4 go-idle last byte", flast[b_fr], 8'h95);
        check(crc_bad == b_crc, "R4 crc7", crc_bad - b_crc, 0);
        check(pre_edges - b_pre == PREB * 8 && pre_mosi_bad == b_pmb, "R2 wake clocks",
              pre_edges - b_pre, PREB * 8);
        check(cs_falls - b_cs == 1, "R5 single select", cs_falls - b_cs, 1);
        check(hi_bad == b_hi, "R3 half period", hi_bad - b_hi, 0);
    endtask

    initial begin
        #(190000 * 10);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5D1A));
        cfg_lat0 = 0; cfg_lat1 = 0; cfg_lat8 = 0; cfg_idle = 0; cfg_echo = 12'h1A5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n && !sclk && mosi && !busy && !done && !err && !fast_ok, "R1 reset",
              {cs_n, sclk, mosi, busy, done, err, fast_ok}, 7'b1010000);

        run_case(0, 0, 0, 0, 12'h1A5);          // nominal
        run_case(7, 7, 7, 2, 12'h1A5);          // R1 on the last poll (R6 boundary)
        run_case(8, 0, 0, 0, 12'h1A5);          // no R1 to go-idle
        run_case(1, 2, 8, 0, 12'h1A5);          // no R1 to interface check
        run_case(0, 1, 0, TRIES - 1, 12'h1A5);  // ready on the last allowed send (R7)
        run_case(0, 0, 0, TRIES, 12'h1A5);      // retries used up
        run_case(0, 0, 3, 0, 12'h1AA);          // echo mismatch (R8)
        run_case(2, 0, 1, 0, 12'h0A5);          // mismatch in the upper nibble

        for (int n = 0; n < 8; n++) begin
            int r0, r1, r8, ri;
            logic [11:0] e;
            r0 = $urandom_range(0, 9); if (r0 > 8) r0 = 8;
            r1 = $urandom_range(0, 9); if (r1 > 8) r1 = 8;
            r8 = $urandom_range(0, 9); if (r8 > 8) r8 = 8;
            ri = $urandom_range(0, TRIES + 1);
            e  = 12'h1A5;
            if ($urandom_range(0, 3) == 0) e = e ^ (12'h1 << $urandom_range(0, 11));
            run_case(r0, r1, r8, ri, e);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule